// File: doc/BRIEF.md
# Conditional Branch and Set-Byte Evaluator

This block sits in the execute stage of a processor core. It receives the first two bytes of an instruction, the five arithmetic flags that are current at that point, the decoded displacement field and the address of the next instruction. From these it decides whether the instruction is a conditional jump (short or near form) or a conditional set-byte. It evaluates the instruction's 4-bit condition code against the flags and returns three results: a single condition-true bit, the byte value a set-byte instruction writes, and the instruction pointer that follows the instruction.

There are sixteen condition codes. Each even code names a basic test. The odd code just after it is the exact negation of that test. The signed tests are built from the sign and overflow flags. The unsigned tests use carry and zero. The displacement is sign-extended to the active operand width, which is 16 or 32 bits and is chosen per instruction by an input. The target wraps at that width. Results appear in registers one cycle after the request. Fetching instructions and writing flags are handled elsewhere.

Top module: `cond_branch_unit`

## Requirements
- R1: While reset is held, and in the first cycle after it, every output is zero.
- R2: A request with `reqValid` high produces its results in the next cycle, with `rspValid` high. In a cycle after no request, `rspValid`, `isJump`, `isSet`, `condTrue`, `setValue` and `target` are all zero.
- R3: The flags input is laid out as bit 0 CF, bit 1 PF, bit 2 ZF, bit 3 SF, bit 4 OF. Codes 0/1 test OF/not OF, codes 2/3 test CF/not CF, and codes 4/5 test ZF/not ZF.
- R4: Code 6 is true when CF or ZF is set. Code 7 is true when both are clear.
- R5: Codes 8/9 test SF/not SF. Codes 10/11 test PF/not PF.
- R6: Code 12 is true when SF differs from OF. Code 13 is true when they are equal. Code 14 is true when SF differs from OF or ZF is set. Code 15 is true when SF equals OF and ZF is clear.
- R7: A first byte of 0x70 plus the code is a short jump. It uses `disp[7:0]` as a signed byte displacement.
- R8: A first byte of 0x0F followed by 0x80 plus the code is a near jump. It uses `disp[15:0]` as a signed value when `wideOp` is 0, and all of `disp` when `wideOp` is 1.
- R9: A first byte of 0x0F followed by 0x90 plus the code is a set-byte. `isSet` is 1, and `setValue` is 1 when the condition holds and 0 otherwise.
- R10: When a jump is taken, `target` is the next pointer plus the sign-extended displacement. When it is not taken, `target` is the next pointer unchanged.
- R11: With `wideOp` 0, all target arithmetic wraps modulo 2^16 and `target[31:16]` is zero. With `wideOp` 1, it wraps modulo 2^32.
- R12: Any other opcode gives `isJump`, `isSet`, `condTrue` and `setValue` all 0, and `target` equal to the next pointer reduced to the operand width.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe |
| opByte0 | input | 8 | First instruction byte |
| opByte1 | input | 8 | Second instruction byte |
| flags | input | 5 | {OF, SF, ZF, PF, CF} |
| disp | input | 32 | Displacement field, low byte used by the short form |
| nextIp | input | 32 | Address of the following instruction |
| wideOp | input | 1 | 1 selects 32-bit operand width, 0 selects 16-bit |
| rspValid | output | 1 | Results valid |
| isJump | output | 1 | Request was a conditional jump |
| isSet | output | 1 | Request was a set-byte |
| condTrue | output | 1 | Condition held for a jump or set-byte |
| setValue | output | 8 | Byte written by a set-byte |
| target | output | 32 | Following instruction pointer |

## Verification
The bench builds the block with its default 32-bit pointer width. The `wideOp` input then reaches both operand widths in one build. Because the pointer is 32 bits wide, the 16-bit wrap at 0xFFFF is directly observable, and so are nonzero upper pointer bits that the narrow mode must clear. Every code is swept against all 32 flag patterns. Random jumps in both widths then run against a reference model.

// File: rtl/cbu_pkg.sv
package cbu_pkg;
  localparam int FLAG_CF = 0;
  localparam int FLAG_PF = 1;
  localparam int FLAG_ZF = 2;
  localparam int FLAG_SF = 3;
  localparam int FLAG_OF = 4;
  localparam int FLAG_N  = 5;

  typedef struct packed {
    logic       jumpEn;
    logic       setEn;
    logic       shortDisp;
    logic [3:0] code;
  } ctrlStrobes_t;
endpackage

// File: rtl/cbu_decode.sv
module cbu_decode
  import cbu_pkg::*;
(
  input  logic [7:0]   opByte0,
  input  logic [7:0]   opByte1,
  output ctrlStrobes_t strobes
);
  localparam logic [3:0] SHORT_HI = 4'h7;
  localparam logic [7:0] ESCAPE   = 8'h0F;
  localparam logic [3:0] NEAR_HI  = 4'h8;
  localparam logic [3:0] SET_HI   = 4'h9;

  logic isShort, isEsc, isNear, isSetF;

  always_comb begin
    isShort = (opByte0[7:4] == SHORT_HI);
    isEsc   = (opByte0 == ESCAPE);
    isNear  = isEsc && (opByte1[7:4] == NEAR_HI);
    isSetF  = isEsc && (opByte1[7:4] == SET_HI);
    strobes.jumpEn    = isShort | isNear;
    strobes.setEn     = isSetF;
    strobes.shortDisp = isShort;
    strobes.code      = isShort ? opByte0[3:0] : opByte1[3:0];
  end
endmodule

// File: rtl/cbu_datapath.sv
module cbu_datapath
  import cbu_pkg::*;
#(
  parameter int IP_W = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  input  ctrlStrobes_t       strobes,
  input  logic [FLAG_N-1:0]  flags,
  input  logic [IP_W-1:0]    disp,
  input  logic [IP_W-1:0]    nextIp,
  input  logic               wideOp,
  output logic               rspValid,
  output logic               isJump,
  output logic               isSet,
  output logic               condTrue,
  output logic [7:0]         setValue,
  output logic [IP_W-1:0]    target
);
  localparam int HALF_W = IP_W / 2;
  localparam logic [IP_W-1:0] NARROW_MASK = {{(IP_W-HALF_W){1'b0}}, {HALF_W{1'b1}}};

  logic            baseCond, cond, taken, anyForm;
  logic [IP_W-1:0] dispExt, sum, widthMask, nextTarget;

  // Even-code test; odd codes invert it
  always_comb begin
    unique case (strobes.code[3:1])
      3'd0: baseCond = flags[FLAG_OF];
      3'd1: baseCond = flags[FLAG_CF];
      3'd2: baseCond = flags[FLAG_ZF];
      3'd3: baseCond = flags[FLAG_CF] | flags[FLAG_ZF];
      3'd4: baseCond = flags[FLAG_SF];
      3'd5: baseCond = flags[FLAG_PF];
      3'd6: baseCond = flags[FLAG_SF] ^ flags[FLAG_OF];
      default: baseCond = (flags[FLAG_SF] ^ flags[FLAG_OF]) | flags[FLAG_ZF];
    endcase
    cond = baseCond ^ strobes.code[0];
  end

  always_comb begin
    if (strobes.shortDisp)
      dispExt = {{(IP_W-8){disp[7]}}, disp[7:0]};
    else if (wideOp)
      dispExt = disp;
    else
      dispExt = {{(IP_W-HALF_W){disp[HALF_W-1]}}, disp[HALF_W-1:0]};
    widthMask  = wideOp ? '1 : NARROW_MASK;
    sum        = nextIp + dispExt;
    anyForm    = strobes.jumpEn | strobes.setEn;
    taken      = strobes.jumpEn & cond;
    nextTarget = (taken ? sum : nextIp) & widthMask;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      isJump   <= 1'b0;
      isSet    <= 1'b0;
      condTrue <= 1'b0;
      setValue <= '0;
      target   <= '0;
    end else begin
      rspValid <= reqValid;
      isJump   <= reqValid & strobes.jumpEn;
      isSet    <= reqValid & strobes.setEn;
      condTrue <= reqValid & anyForm & cond;
      setValue <= {7'd0, reqValid & strobes.setEn & cond};
      target   <= reqValid ? nextTarget : '0;
    end
  end

  // R9: set-byte writes only 0 or 1, matching the condition
  a_r9_set_value: assert property (@(posedge clk) disable iff (!rstN)
    isSet |-> (setValue == {7'd0, condTrue}));
  // R2: idle cycle gives quiet outputs
  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !rspValid |-> (!isJump && !isSet && !condTrue && target == '0));
  // R2: one-cycle latency
  a_r2_latency: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid);
  // R11: narrow mode clears the upper half of the target
  a_r11_narrow_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !wideOp) |=> (target[IP_W-1:HALF_W] == '0));
  // R10: a jump that is not taken falls through to the next pointer
  a_r10_fallthrough: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && wideOp) |=> ((isJump && !condTrue) -> (target == $past(nextIp))));
  // R12: jump and set-byte are never reported together
  a_r12_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(isJump && isSet));
endmodule

// File: rtl/cond_branch_unit.sv
module cond_branch_unit
  import cbu_pkg::*;
#(
  parameter int IP_W = 32
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            reqValid,
  input  logic [7:0]      opByte0,
  input  logic [7:0]      opByte1,
  input  logic [4:0]      flags,
  input  logic [IP_W-1:0] disp,
  input  logic [IP_W-1:0] nextIp,
  input  logic            wideOp,
  output logic            rspValid,
  output logic            isJump,
  output logic            isSet,
  output logic            condTrue,
  output logic [7:0]      setValue,
  output logic [IP_W-1:0] target
);
  ctrlStrobes_t strobes;

  cbu_decode u_decode (
    .opByte0 (opByte0),
    .opByte1 (opByte1),
    .strobes (strobes)
  );

  cbu_datapath #(.IP_W(IP_W)) u_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .strobes  (strobes),
    .flags    (flags),
    .disp     (disp),
    .nextIp   (nextIp),
    .wideOp   (wideOp),
    .rspValid (rspValid),
    .isJump   (isJump),
    .isSet    (isSet),
    .condTrue (condTrue),
    .setValue (setValue),
    .target   (target)
  );
endmodule

// File: tb/sim_cond_branch_unit.sv
`timescale 1ns/1ps
module sim_cond_branch_unit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [7:0]  opByte0 = '0, opByte1 = '0;
  logic [4:0]  flags = '0;
  logic [31:0] disp = '0, nextIp = '0;
  logic        wideOp = 1'b0;
  logic        rspValid, isJump, isSet, condTrue;
  logic [7:0]  setValue;
  logic [31:0] target;
  int nChecks = 0, nFail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  cond_branch_unit u0 (.*);

  // flags: [0]CF [1]PF [2]ZF [3]SF [4]OF
  function automatic logic condRef(input logic [3:0] c, input logic [4:0] f);
    logic cf, pf, zf, sf, ov, r;
    cf = f[0]; pf = f[1]; zf = f[2]; sf = f[3]; ov = f[4];
    case (c)
      4'd0: r = ov;         4'd1: r = !ov;
      4'd2: r = cf;         4'd3: r = !cf;
      4'd4: r = zf;         4'd5: r = !zf;
      4'd6: r = cf || zf;   4'd7: r = !cf && !zf;
      4'd8: r = sf;         4'd9: r = !sf;
      4'd10: r = pf;        4'd11: r = !pf;
      4'd12: r = sf != ov;  4'd13: r = sf == ov;
      4'd14: r = (sf != ov) || zf;
      default: r = (sf == ov) && !zf;
    endcase
    return r;
  endfunction

  function automatic logic [31:0] targetRef(input bit isShort, input bit isJ,
      input bit wide, input logic [31:0] d, input logic [31:0] nip, input logic c);
    logic [31:0] ext, res;
    if (isShort) ext = {{24{d[7]}}, d[7:0]};
    else if (wide) ext = d;
    else ext = {{16{d[15]}}, d[15:0]};
    res = (isJ && c) ? nip + ext : nip;
    if (!wide) res = {16'd0, res[15:0]};
    return res;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [7:0] b0, input logic [7:0] b1, input logic [4:0] f,
      input logic [31:0] d, input logic [31:0] nip, input logic w);
    @(negedge clk);
    reqValid = 1'b1; opByte0 = b0; opByte1 = b1; flags = f;
    disp = d; nextIp = nip; wideOp = w;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    logic c;
    logic [31:0] d, nip;
    logic [3:0] cc;
    logic [4:0] f;
    bit w, sh;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 rspValid", {31'd0, rspValid}, 32'd0);
    check("R1 target", target, 32'd0);
    check("R1 setValue", {24'd0, setValue}, 32'd0);
    @(negedge clk) rstN = 1'b1;
    @(negedge clk);
    check("R1 after release", {28'd0, rspValid, isJump, isSet, condTrue}, 32'd0);

    // R3 R4 R5 R6 R9: full sweep using set-byte form
    for (int ci = 0; ci < 16; ci++) begin
      for (int fi = 0; fi < 32; fi++) begin
        drive(8'h0F, 8'h90 + 8'(ci), 5'(fi), 32'h0, 32'h1000, 1'b1);
        c = condRef(4'(ci), 5'(fi));
        check(ci < 6 ? "R3 cond" : ci < 8 ? "R4 cond" : ci < 12 ? "R5 cond" : "R6 cond",
              {31'd0, condTrue}, {31'd0, c});
        check("R9 setValue", {24'd0, setValue}, {31'd0, c});
        check("R9 isSet", {30'd0, isSet, isJump}, 32'd2);
        check("R2 rspValid", {31'd0, rspValid}, 32'd1);
      end
    end
    @(negedge clk);
    check("R2 idle", {28'd0, rspValid, isJump, isSet, condTrue}, 32'd0);
    check("R2 idle target", target, 32'd0);

    // R7 short backward jump taken: code 4 with ZF set, disp -3
    drive(8'h74, 8'h00, 5'b00100, 32'h000000FD, 32'h00012000, 1'b1);
    check("R7 short target", target, 32'h00011FFD);
    check("R7 isJump", {31'd0, isJump}, 32'd1);
    // R10 not taken
    drive(8'h74, 8'h00, 5'b00000, 32'h000000FD, 32'h00012000, 1'b1);
    check("R10 fallthrough", target, 32'h00012000);
    check("R10 condTrue", {31'd0, condTrue}, 32'd0);
    // R8 near 16-bit negative disp, R11 wrap
    drive(8'h0F, 8'h85, 5'b00000, 32'hABCD0002, 32'h0005FFFF, 1'b0);
    check("R11 narrow wrap", target, 32'h00000001);
    drive(8'h0F, 8'h84, 5'b00100, 32'h0000FFFE, 32'h00050001, 1'b0);
    check("R8 narrow negative", target, 32'h0000FFFF);
    // R8 32-bit
    drive(8'h0F, 8'h8F, 5'b00000, 32'h80000000, 32'h80000010, 1'b1);
    check("R11 wide wrap", target, 32'h00000010);
    // R12 unrelated opcodes
    drive(8'h90, 8'h94, 5'b11111, 32'h00000010, 32'h12345678, 1'b0);
    check("R12 other flags", {28'd0, isJump, isSet, condTrue, setValue[0]}, 32'd0);
    check("R12 other target", target, 32'h00005678);
    drive(8'h0F, 8'hA4, 5'b00000, 32'h00000010, 32'h12345678, 1'b1);
    check("R12 escape other", {28'd0, isJump, isSet, condTrue, setValue[0]}, 32'd0);
    check("R12 escape target", target, 32'h12345678);

    // Random jumps, R7 R8 R10 R11
    for (int i = 0; i < 400; i++) begin
      cc = 4'($urandom); f = 5'($urandom); d = $urandom; nip = $urandom;
      w = 1'($urandom); sh = 1'($urandom);
      drive(sh ? (8'h70 + 8'(cc)) : 8'h0F, sh ? 8'h00 : (8'h80 + 8'(cc)), f, d, nip, w);
      c = condRef(cc, f);
      check(sh ? "R7 random target" : "R8 random target", target,
            targetRef(sh, 1'b1, w, d, nip, c));
      check("R10 random cond", {31'd0, condTrue}, {31'd0, c});
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end
endmodule